// File: doc/BRIEF.md
# Serial Port Interrupt Source Unit

This block turns the event signals of a serial port into one interrupt request for a processor. Each of eight event causes owns one bit of a pending-status register. A mask register picks which pending causes may raise the shared request line. The line is presented at one fixed priority level, and a single handler serves every cause. Pulse-type causes latch and stay pending until software clears them. Level-type causes, such as "transmitter can take a byte", follow their input. The receive-character cause clears as a side effect of reading the received byte.

When the processor acknowledges an interrupt at this unit's level, the unit drives its programmable 8-bit vector onto a dedicated vector bus. The processor does not derive a vector from the level. Software reaches the status, mask, vector and received-byte registers over a byte-wide memory-mapped bus. The shifter that produces the events is outside this block.

Top module: `uart_irq_unit`

## Requirements
- R1: After synchronous reset the mask register reads 0x00, the vector register reads 0x0F, the status register reads 0x00, `irq_req` is 0 and `irq_level` is 0.
- R2: A pulse on `evt_pulse[i]` for a pulse-type cause sets status bit i (address 0) at the next clock edge. The bit stays set until it is cleared.
- R3: `irq_req` is 1 exactly when some status bit and the same mask bit (address 1) are both 1. Writing 0x20 to the mask enables only the receive cause, which is bit 5.
- R4: A read of address 3 returns `rx_byte` and clears status bit 5 at that clock edge. A later receive pulse (`evt_pulse[5]`) sets the bit again.
- R5: Status bit 2, the transmitter-ready cause, is a level cause. It equals `evt_level[2]` as registered at the previous clock edge, and it ignores `evt_pulse[2]` and status writes.
- R6: Writing a byte to address 0 clears every pulse-type status bit whose written bit is 1, except bit 5. Bit 5 is left unchanged by such a write.
- R7: Address 2 holds the vector and can be written and read back. While `ack_valid` is 1 and `ack_level` equals 4, `vec_en` is 1 and `vec_data` equals the vector. Otherwise `vec_en` is 0 and `vec_data` is 0.
- R8: `irq_level` is 4 while `irq_req` is 1, and 0 otherwise.
- R9: Addresses 4 to 7 read as 0x00, and writes to them change no register.
- R10: When a pulse sets a cause in the same cycle that the cause is being cleared, the set wins and the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read, 0 when idle |
| evt_pulse | input | 8 | One-cycle event pulses for pulse-type causes |
| evt_level | input | 8 | Level inputs for level-type causes |
| rx_byte | input | 8 | Character currently held by the receive buffer |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| irq_req | output | 1 | Shared interrupt request |
| irq_level | output | 3 | Requested level, 0 when idle |
| vec_en | output | 1 | Vector bus drive enable |
| vec_data | output | 8 | Vector value during acknowledge |

## Verification
The bench builds the unit with its default parameters. These are a vector reset value of 0x0F, request level 4, bit 2 as the only level cause and bit 5 as the receive cause. With these values the bench can reach the mixed behaviour of a single register: a sticky pulse bit, a level bit, and a receive bit cleared only by a data read, all side by side. Acknowledges at level 4 and at a neighbouring level exercise the vector-drive match and its rejection. A receive pulse that lands in the same cycle as the data read exercises the set-over-clear priority.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int EVT_N  = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int LVL_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 3'd0,
        ADR_MASK   = 3'd1,
        ADR_VECTOR = 3'd2,
        ADR_RXDATA = 3'd3
    } reg_addr_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic addr_is(input logic [ADDR_W-1:0] a, input reg_addr_e r);
        return a == r;
    endfunction
endpackage

// File: rtl/uirq_cfg_regs.sv
module uirq_cfg_regs
    import uirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              vec_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] vec_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            vec_q  <= VEC_RESET;
        end else begin
            if (mask_we) mask_q <= wdata;
            if (vec_we)  vec_q  <= wdata;
        end
    end

    assert_reset_cfg_R1: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && vec_q == VEC_RESET));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/uirq_cause_bank.sv
module uirq_cause_bank
    import uirq_pkg::*;
#(
    parameter logic [EVT_N-1:0] LEVEL_BITS = 8'h04,
    parameter int               RX_BIT     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] evt_pulse,
    input  logic [EVT_N-1:0] evt_level,
    input  logic             clr_we,
    input  logic [EVT_N-1:0] clr_bits,
    input  logic             rx_read,
    output logic [EVT_N-1:0] status_q
);
    for (genvar i = 0; i < EVT_N; i++) begin : g_cause
        if (LEVEL_BITS[i]) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) status_q[i] <= 1'b0;
                else     status_q[i] <= evt_level[i];
            end
            assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> status_q[i] == $past(evt_level[i]));
        end else if (i == RX_BIT) begin : g_rx
            always_ff @(posedge clk) begin
                if (rst)               status_q[i] <= 1'b0;
                else if (evt_pulse[i]) status_q[i] <= 1'b1;
                else if (rx_read)      status_q[i] <= 1'b0;
            end
            assert_rx_clear_R4: assert property (@(posedge clk) disable iff (rst)
                (rx_read && !evt_pulse[i]) |=> !status_q[i]);
            assert_rx_w1c_ignored_R6: assert property (@(posedge clk) disable iff (rst)
                (!rx_read && !evt_pulse[i]) |=> $stable(status_q[i]));
        end else begin : g_pulse
            always_ff @(posedge clk) begin
                if (rst)                          status_q[i] <= 1'b0;
                else if (evt_pulse[i])            status_q[i] <= 1'b1;
                else if (clr_we && clr_bits[i])   status_q[i] <= 1'b0;
            end
            assert_pulse_set_R2: assert property (@(posedge clk) disable iff (rst)
                evt_pulse[i] |=> status_q[i]);
            assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (rst)
                (clr_we && clr_bits[i] && !evt_pulse[i]) |=> !status_q[i]);
        end
    end
endmodule

// File: rtl/uirq_vec_drive.sv
module uirq_vec_drive
    import uirq_pkg::*;
#(
    parameter logic [LVL_W-1:0] IRQ_LEVEL = 3'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    input  logic [DATA_W-1:0] vec_q,
    output logic              vec_en,
    output logic [DATA_W-1:0] vec_data
);
    logic hit;

    always_comb begin
        hit      = ack_valid && (ack_level == IRQ_LEVEL);
        vec_en   = hit;
        vec_data = hit ? vec_q : '0;
    end

    assert_vec_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !ack_valid |-> (!vec_en && vec_data == '0));
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] VEC_RESET  = 8'h0F,
    parameter logic [LVL_W-1:0]  IRQ_LEVEL  = 3'd4,
    parameter logic [EVT_N-1:0]  LEVEL_BITS = 8'h04,
    parameter int                RX_BIT     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic [EVT_N-1:0]  evt_level,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level,
    output logic              vec_en,
    output logic [DATA_W-1:0] vec_data
);
    bus_req_t          req;
    logic [DATA_W-1:0] mask_q, vec_q;
    logic [EVT_N-1:0]  status_q;
    logic              mask_we, vec_we, clr_we, rx_read;

    always_comb begin
        req.rd    = bus_sel && !bus_wr;
        req.wr    = bus_sel && bus_wr;
        req.addr  = bus_addr;
        req.wdata = bus_wdata;
        mask_we   = req.wr && addr_is(req.addr, ADR_MASK);
        vec_we    = req.wr && addr_is(req.addr, ADR_VECTOR);
        clr_we    = req.wr && addr_is(req.addr, ADR_STATUS);
        rx_read   = req.rd && addr_is(req.addr, ADR_RXDATA);
    end

    uirq_cfg_regs #(.VEC_RESET(VEC_RESET)) u_cfg (
        .clk(clk), .rst(rst), .mask_we(mask_we), .vec_we(vec_we),
        .wdata(req.wdata), .mask_q(mask_q), .vec_q(vec_q)
    );

    uirq_cause_bank #(.LEVEL_BITS(LEVEL_BITS), .RX_BIT(RX_BIT)) u_cause (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .evt_level(evt_level),
        .clr_we(clr_we), .clr_bits(req.wdata), .rx_read(rx_read),
        .status_q(status_q)
    );

    uirq_vec_drive #(.IRQ_LEVEL(IRQ_LEVEL)) u_vec (
        .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_level(ack_level),
        .vec_q(vec_q), .vec_en(vec_en), .vec_data(vec_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            case (req.addr)
                ADR_STATUS: bus_rdata = status_q;
                ADR_MASK:   bus_rdata = mask_q;
                ADR_VECTOR: bus_rdata = vec_q;
                ADR_RXDATA: bus_rdata = rx_byte;
                default:    bus_rdata = '0;
            endcase
        end
        irq_req   = |(status_q & mask_q);
        irq_level = irq_req ? IRQ_LEVEL : '0;
    end

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_req);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!irq_req && irq_level == '0));
endmodule

// File: tb/uart_irq_unit_test.sv
module uart_irq_unit_test;
    logic       clk = 0;
    logic       rst = 1;
    logic       bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [7:0] evt_pulse = 0, evt_level = 0, rx_byte = 0;
    logic       ack_valid = 0;
    logic [2:0] ack_level = 0;
    logic       irq_req, vec_en;
    logic [2:0] irq_level;
    logic [7:0] vec_data;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_unit uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .evt_level(evt_level), .rx_byte(rx_byte), .ack_valid(ack_valid),
        .ack_level(ack_level), .irq_req(irq_req), .irq_level(irq_level),
        .vec_en(vec_en), .vec_data(vec_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic pulse(input logic [7:0] b);
        @(negedge clk); evt_pulse = b;
        @(negedge clk); evt_pulse = 0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(3'd1, d); check("R1 mask", d, 8'h00);
        rd(3'd2, d); check("R1 vector", d, 8'h0F);
        rd(3'd0, d); check("R1 status", d, 8'h00);
        check("R1 irq", {7'd0, irq_req}, 8'h00);
        check("R1 irq_level", {5'd0, irq_level}, 8'h00);
    endtask

    task automatic t_sticky;
        logic [7:0] d;
        pulse(8'h01);
        rd(3'd0, d); check("R2 status set", d, 8'h01);
        repeat (5) @(negedge clk);
        rd(3'd0, d); check("R2 status held", d, 8'h01);
        check("R3 masked no irq", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_mask;
        wr(3'd1, 8'h20); #2;
        check("R3 bit0 not enabled", {7'd0, irq_req}, 8'h00);
        check("R8 idle level", {5'd0, irq_level}, 8'h00);
        pulse(8'h20); #2;
        check("R3 rx enabled irq", {7'd0, irq_req}, 8'h01);
        check("R8 level 4", {5'd0, irq_level}, 8'h04);
        wr(3'd1, 8'h01); #2;
        check("R3 bit0 enabled irq", {7'd0, irq_req}, 8'h01);
        wr(3'd1, 8'h00); #2;
        check("R3 mask zero", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_w1c;
        logic [7:0] d;
        pulse(8'h08);
        rd(3'd0, d); check("R2 two sticky", d, 8'h29);
        wr(3'd0, 8'h01);
        rd(3'd0, d); check("R6 clear bit0", d, 8'h28);
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R6 rx kept", d, 8'h20);
    endtask

    task automatic t_rx;
        logic [7:0] d;
        rx_byte = 8'h5A;
        rd(3'd3, d); check("R4 rx data", d, 8'h5A);
        rd(3'd0, d); check("R4 rx cleared", d, 8'h00);
        pulse(8'h20);
        rd(3'd0, d); check("R4 rx set again", d, 8'h20);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd3; evt_pulse = 8'h20;
        @(negedge clk); bus_sel = 0; evt_pulse = 0;
        rd(3'd0, d); check("R10 set beats read clear", d, 8'h20);
        rd(3'd3, d);
        rd(3'd0, d); check("R4 rx cleared again", d, 8'h00);
        pulse(8'h02);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h02; evt_pulse = 8'h02;
        @(negedge clk); bus_sel = 0; bus_wr = 0; evt_pulse = 0;
        rd(3'd0, d); check("R10 set beats w1c", d, 8'h02);
        wr(3'd0, 8'h02);
    endtask

    task automatic t_level;
        logic [7:0] d;
        @(negedge clk); evt_level = 8'h04;
        rd(3'd0, d); check("R5 level high", d, 8'h04);
        wr(3'd0, 8'h04);
        rd(3'd0, d); check("R5 w1c ignored", d, 8'h04);
        @(negedge clk); evt_level = 8'h00;
        rd(3'd0, d); check("R5 level low", d, 8'h00);
        pulse(8'h04);
        rd(3'd0, d); check("R5 pulse ignored", d, 8'h00);
    endtask

    task automatic t_vec;
        logic [7:0] d;
        wr(3'd2, 8'h1C);
        rd(3'd2, d); check("R7 vector readback", d, 8'h1C);
        @(negedge clk); ack_valid = 1; ack_level = 3'd4; #2;
        check("R7 ack en", {7'd0, vec_en}, 8'h01);
        check("R7 ack data", vec_data, 8'h1C);
        ack_level = 3'd3; #2;
        check("R7 other level en", {7'd0, vec_en}, 8'h00);
        check("R7 other level data", vec_data, 8'h00);
        @(negedge clk); ack_valid = 0;
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr(3'd1, 8'h11);
        wr(3'd5, 8'hFF);
        rd(3'd5, d); check("R9 unmapped read", d, 8'h00);
        rd(3'd1, d); check("R9 mask untouched", d, 8'h11);
        rd(3'd2, d); check("R9 vector untouched", d, 8'h1C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_sticky();
        t_mask();
        t_w1c();
        t_rx();
        t_level();
        t_vec();
        t_unmapped();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule